// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a 2048-word by 8-bit synchronous memory with two fully independent access ports, named left and right. Each port has its own chip enable, write enable, output enable, address and data buses, and may read or write any word in any cycle. Writes take effect at the clock edge. Reads are registered: the word appears on the port's read bus one cycle after the request, qualified by a read-valid strobe.

The two top words double as mailboxes. A write by the right port to word 0x7FE raises an interrupt toward the left port. A write by the left port to word 0x7FF raises an interrupt toward the right port. Each interrupt stays raised until its receiving port reads the same word. The message bytes are ordinary storage, so the receiver reads the message and clears the interrupt in the same access. A mailbox-enable input switches this function off, and the two words then act as plain RAM. Arbitration between colliding ports belongs to a separate block. This block only defines what is stored when both ports write one word in the same cycle.

Write requests are always accepted, so the write path has an implicit ready that is permanently high. The read stream has no back-pressure: a consumer must take each word in the cycle its valid strobe is high.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is applied, and right after it, both interrupt outputs are high (deasserted), both read-valid outputs are low and both read buses are zero.
- R2: A port with chip enable high and write enable high stores its write data at its address at the clock edge. A port with chip enable high, write enable low and output enable high returns the addressed word on its read bus in the next cycle, with read-valid high. This holds for either port and any address.
- R3: A port with chip enable low performs no access. It stores nothing, returns nothing, and leaves both interrupt flags unchanged.
- R4: When a port's request is not a read with output enabled (chip enable low, write enable high, or output enable low), its read-valid is low and its read bus is zero in the next cycle.
- R5: With mailbox enabled, a right-port write to address 0x7FE drives the left interrupt output low from the next cycle. It stays low until it is cleared.
- R6: With mailbox enabled, a left-port read of address 0x7FE (chip enable high, write enable low, with output enable either way) returns the left interrupt output high in the next cycle.
- R7: With mailbox enabled, a left-port write to address 0x7FF drives the right interrupt output low from the next cycle. It stays low until it is cleared.
- R8: With mailbox enabled, a right-port read of address 0x7FF (output enable either way) returns the right interrupt output high in the next cycle.
- R9: Words 0x7FE and 0x7FF hold the written message bytes and read back like any other word.
- R10: While mailbox enable is low, both interrupt outputs are high in the same cycle, pending flags are discarded, and writes to 0x7FE or 0x7FF raise nothing.
- R11: If a flag is set and cleared in the same cycle, the set wins and the interrupt stays asserted.
- R12: A read of a word that the other port writes in the same cycle returns the old content. When both ports write the same word in one cycle, the left port's data is stored.
- R13: A flag is raised only by the opposite port's write and cleared only by its own port's read. A read of a mailbox by the sending port, or a write by the receiving port, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Mailbox interrupt function enable |
| l_ce | input | 1 | Left chip enable |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left registered read data, zero when not valid |
| l_rvalid | output | 1 | Left read data valid |
| l_int_n | output | 1 | Left interrupt, active low |
| r_ce | input | 1 | Right chip enable |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right registered read data, zero when not valid |
| r_rvalid | output | 1 | Right read data valid |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
A corrupted interrupt flag shows on an interrupt pin one cycle after the offending access and stays wrong until the receiving port reads its mailbox. The tests therefore check the pin on the cycle after every set, clear and non-clearing access. A wrong storage word or a wrong write-priority choice is hidden until some port reads that word, so every write is read back, from the other port where possible, and the word is checked on the cycle its valid strobe rises. Stale or ungated read registers show at once as a nonzero bus or a high valid after a non-read request.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic ce, input logic we);
    if (!ce)     return ACC_NONE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

endpackage

// File: rtl/mbox_dpram_array.sv
module mbox_dpram_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter int NPORT  = 2
) (
  input  logic                           clk,
  input  logic [NPORT-1:0]               wr_en,
  input  logic [NPORT-1:0][ADDR_W-1:0]   addr,
  input  logic [NPORT-1:0][DATA_W-1:0]   wdata,
  output logic [NPORT-1:0][DATA_W-1:0]   rword
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Highest port index is applied first, so port 0 (left) lands last and wins.
  always_ff @(posedge clk) begin
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  // Combinational look-up: the value before this edge's writes (read-old).
  always_comb begin
    for (int p = 0; p < NPORT; p++) rword[p] = mem[addr[p]];
  end

endmodule

// File: rtl/mbox_dpram_port.sv
module mbox_dpram_port
  import mbox_dpram_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int OWN_ADDR  = 2046,
  parameter int POST_ADDR = 2047
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] mem_word,
  output logic              wr_en,
  output logic              post_hit,
  output logic              own_rd_hit,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_ADDR);
  localparam logic [ADDR_W-1:0] POST_A = ADDR_W'(POST_ADDR);

  acc_kind_e kind;
  logic      rd_acc;
  logic      drive;

  always_comb begin
    kind       = classify(ce, we);
    wr_en      = (kind == ACC_WRITE);
    rd_acc     = (kind == ACC_READ);
    drive      = rd_acc && oe;
    post_hit   = wr_en && (addr == POST_A);
    own_rd_hit = rd_acc && (addr == OWN_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= drive;
      rdata  <= drive ? mem_word : '0;
    end
  end

endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic int_n
);
  logic flag_q;

  // Set outranks clear; a disabled mailbox drops any pending flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag_q <= 1'b0;
    else if (!en)  flag_q <= 1'b0;
    else if (set)  flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assign int_n = ~(flag_q & en);

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbox_en,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_int_n,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_int_n
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NPORT = 2;
  // Port 0 = left, port 1 = right. Mailbox of port p is DEPTH-2+p.
  localparam int MBOX_BASE = DEPTH - 2;

  logic [NPORT-1:0]             ce, we, oe;
  logic [NPORT-1:0][ADDR_W-1:0] addr;
  logic [NPORT-1:0][DATA_W-1:0] wdata, rword, rdata;
  logic [NPORT-1:0]             wr_en, post_hit, own_rd_hit, rvalid, int_n;

  always_comb begin
    ce    = {r_ce, l_ce};
    we    = {r_we, l_we};
    oe    = {r_oe, l_oe};
    addr  = {r_addr, l_addr};
    wdata = {r_wdata, l_wdata};
  end

  mbox_dpram_array #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT)
  ) u_array (
    .clk   (clk),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rword (rword)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int OTHER = NPORT - 1 - p;

    mbox_dpram_port #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .OWN_ADDR (MBOX_BASE + p),
      .POST_ADDR(MBOX_BASE + OTHER)
    ) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce         (ce[p]),
      .we         (we[p]),
      .oe         (oe[p]),
      .addr       (addr[p]),
      .mem_word   (rword[p]),
      .wr_en      (wr_en[p]),
      .post_hit   (post_hit[p]),
      .own_rd_hit (own_rd_hit[p]),
      .rdata      (rdata[p]),
      .rvalid     (rvalid[p])
    );

    mbox_dpram_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (mbox_en),
      .set   (post_hit[OTHER]),
      .clr   (own_rd_hit[p]),
      .int_n (int_n[p])
    );
  end

  assign l_rdata  = rdata[0];
  assign r_rdata  = rdata[1];
  assign l_rvalid = rvalid[0];
  assign r_rvalid = rvalid[1];
  assign l_int_n  = int_n[0];
  assign r_int_n  = int_n[1];

endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mbox_en,
  input logic              l_ce,
  input logic              l_we,
  input logic              l_oe,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_wdata,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_rvalid,
  input logic              l_int_n,
  input logic              r_ce,
  input logic              r_we,
  input logic              r_oe,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_wdata,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_rvalid,
  input logic              r_int_n
);
  localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'((1 << ADDR_W) - 2);
  localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'((1 << ADDR_W) - 1);

  logic set_l, set_r, clr_l, clr_r;
  assign set_l = mbox_en && r_ce && r_we && (r_addr == BOX_L);
  assign set_r = mbox_en && l_ce && l_we && (l_addr == BOX_R);
  assign clr_l = l_ce && !l_we && (l_addr == BOX_L);
  assign clr_r = r_ce && !r_we && (r_addr == BOX_R);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (l_int_n && r_int_n && !l_rvalid && !r_rvalid));

  a_r4_left_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_ce && !l_we && l_oe) |=> (!l_rvalid && l_rdata == '0));

  a_r4_right_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_ce && !r_we && r_oe) |=> (!r_rvalid && r_rdata == '0));

  a_r5_left_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_l |=> (!l_int_n || !mbox_en));

  a_r6_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_l && !set_l) |=> l_int_n);

  a_r7_right_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_r |=> (!r_int_n || !mbox_en));

  a_r8_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_r && !set_r) |=> r_int_n);

  a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |-> (l_int_n && r_int_n));

  a_r13_left_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_int_n) |-> $past(set_l));

  a_r13_right_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_int_n) |-> $past(set_r));

endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/mbox_dpram_bench.sv
module mbox_dpram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam logic [AW-1:0] BOX_L = 11'h7FE;
  localparam logic [AW-1:0] BOX_R = 11'h7FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbox_en = 1'b0;
  logic l_ce = 0, l_we = 0, l_oe = 0, r_ce = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_rvalid, r_rvalid, l_int_n, r_int_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mbox_dpram u_mbox_dpram (
    .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_rvalid(l_rvalid), .l_int_n(l_int_n),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_rvalid(r_rvalid), .r_int_n(r_int_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drv_l(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic drv_r(input logic ce, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, '0, '0);
    drv_r(0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    check("R1 l_int_n", l_int_n, 1);
    check("R1 r_int_n", r_int_n, 1);
    check("R1 l_rvalid", l_rvalid, 0);
    check("R1 r_rvalid", r_rvalid, 0);
    check("R1 l_rdata", l_rdata, 0);
    check("R1 r_rdata", r_rdata, 0);
    rst_n = 1'b1;
    tick();
    check("R1 after release", {l_int_n, r_int_n, l_rvalid, r_rvalid}, 4'b1100);
  endtask

  task automatic t_basic_rw();
    drv_l(1, 1, 0, 11'h010, 8'hA5);
    drv_r(1, 1, 0, 11'h123, 8'h3C);
    tick();
    drv_l(1, 1, 0, 11'h000, 8'h81);
    drv_r(1, 1, 0, 11'h7FD, 8'h6E);
    tick();
    drv_l(1, 0, 1, 11'h123, '0);
    drv_r(1, 0, 1, 11'h010, '0);
    tick();
    check("R2 left reads right write", l_rdata, 8'h3C);
    check("R2 left rvalid", l_rvalid, 1);
    check("R2 right reads left write", r_rdata, 8'hA5);
    check("R2 right rvalid", r_rvalid, 1);
    drv_l(1, 0, 1, 11'h7FD, '0);
    drv_r(1, 0, 1, 11'h000, '0);
    tick();
    check("R2 left reads 0x7FD", l_rdata, 8'h6E);
    check("R2 right reads 0x000", r_rdata, 8'h81);
    idle();
    tick();
  endtask

  task automatic t_deselect();
    mbox_en = 1'b1;
    drv_l(0, 1, 1, 11'h010, 8'hFF);
    drv_r(0, 1, 1, BOX_L, 8'h99);
    tick();
    check("R3 no read when deselected", l_rvalid, 0);
    check("R3 no flag from deselected write", l_int_n, 1);
    drv_l(1, 0, 1, 11'h010, '0);
    drv_r(0, 0, 1, 11'h010, '0);
    tick();
    check("R3 word kept", l_rdata, 8'hA5);
    check("R3 right deselected read", {r_rvalid, r_rdata}, 0);
    idle();
    tick();
  endtask

  task automatic t_oe();
    drv_l(1, 0, 0, 11'h010, '0);
    drv_r(1, 1, 1, 11'h300, 8'h44);
    tick();
    check("R4 oe low gives no data", {l_rvalid, l_rdata}, 0);
    check("R4 write gives no data", {r_rvalid, r_rdata}, 0);
    idle();
    tick();
  endtask

  task automatic t_left_mbox();
    drv_r(1, 1, 0, BOX_L, 8'h5A);
    tick();
    idle();
    check("R5 left interrupt raised", l_int_n, 0);
    check("R5 right interrupt untouched", r_int_n, 1);
    tick();
    tick();
    check("R5 left interrupt held", l_int_n, 0);
    drv_r(1, 0, 1, BOX_L, '0);
    tick();
    check("R13 sender read does not clear", l_int_n, 0);
    check("R9 sender reads message", r_rdata, 8'h5A);
    drv_r(0, 0, 0, '0, '0);
    drv_l(1, 0, 1, BOX_L, '0);
    tick();
    check("R6 left read clears", l_int_n, 1);
    check("R9 receiver reads message", l_rdata, 8'h5A);
    idle();
    tick();
  endtask

  task automatic t_right_mbox();
    drv_l(1, 1, 0, BOX_R, 8'hC3);
    tick();
    check("R7 right interrupt raised", r_int_n, 0);
    check("R7 left interrupt untouched", l_int_n, 1);
    drv_l(1, 0, 1, BOX_R, '0);
    tick();
    check("R13 sender read does not clear", r_int_n, 0);
    drv_l(0, 0, 0, '0, '0);
    drv_r(1, 1, 0, BOX_R, 8'hC3);
    tick();
    check("R13 receiver write does not clear", r_int_n, 0);
    drv_r(1, 0, 0, BOX_R, '0);
    tick();
    check("R8 right read with oe low clears", r_int_n, 1);
    check("R4 oe low read has no data", r_rvalid, 0);
    drv_r(1, 0, 1, BOX_R, '0);
    tick();
    check("R9 right reads message", r_rdata, 8'hC3);
    check("R8 stays clear", r_int_n, 1);
    idle();
    tick();
  endtask

  task automatic t_priority();
    drv_r(1, 1, 0, BOX_L, 8'h5B);
    tick();
    check("R5 raised before race", l_int_n, 0);
    drv_r(1, 1, 0, BOX_L, 8'h77);
    drv_l(1, 0, 1, BOX_L, '0);
    tick();
    check("R11 set beats clear", l_int_n, 0);
    check("R12 read returns old word", l_rdata, 8'h5B);
    drv_r(0, 0, 0, '0, '0);
    tick();
    check("R12 new word stored", l_rdata, 8'h77);
    check("R6 cleared afterwards", l_int_n, 1);
    idle();
    tick();
  endtask

  task automatic t_collide();
    drv_l(1, 1, 0, 11'h200, 8'h11);
    drv_r(1, 1, 0, 11'h200, 8'h22);
    tick();
    drv_l(0, 0, 0, '0, '0);
    drv_r(1, 0, 1, 11'h200, '0);
    tick();
    check("R12 left write wins", r_rdata, 8'h11);
    idle();
    tick();
  endtask

  task automatic t_disable();
    drv_r(1, 1, 0, BOX_L, 8'h31);
    tick();
    idle();
    check("R5 raised before disable", l_int_n, 0);
    mbox_en = 1'b0;
    #1;
    check("R10 output released at once", l_int_n, 1);
    tick();
    mbox_en = 1'b1;
    #1;
    check("R10 pending flag discarded", l_int_n, 1);
    mbox_en = 1'b0;
    drv_l(1, 1, 0, BOX_R, 8'h42);
    drv_r(1, 1, 0, BOX_L, 8'h24);
    tick();
    check("R10 no left interrupt", l_int_n, 1);
    check("R10 no right interrupt", r_int_n, 1);
    drv_l(1, 0, 1, BOX_L, '0);
    drv_r(1, 0, 1, BOX_R, '0);
    tick();
    check("R10 0x7FE plain RAM", l_rdata, 8'h24);
    check("R10 0x7FF plain RAM", r_rdata, 8'h42);
    idle();
    tick();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_basic_rw();
    t_deselect();
    t_oe();
    t_left_mbox();
    t_right_mbox();
    t_priority();
    t_collide();
    t_disable();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule